// File: doc/BRIEF.md
# Tagged Adaptive Sequential Prefetcher

This block sits beside a cache and watches its demand accesses. Whenever a demand reference to block `b` qualifies as a trigger, it emits a burst of prefetch block addresses `b+1 .. b+K`, one per clock. The burst length `K` (the degree) is not fixed. The block counts how many of its prefetches are later referenced and adjusts `K` at run time.

Two trigger policies are selectable with `mode_tagged`. With the input low, only demand misses trigger. With it high, the block also remembers which blocks arrived by prefetch, using one mark bit per block. The first demand hit on a marked block clears the mark and triggers a new burst, so a sequential stream keeps running ahead of the processor. The marks sit in a small direct-mapped store indexed by the low block-address bits. Each entry also holds the remaining upper bits, so an aliasing block cannot consume another block's mark.

Fills from the cache tell the block which blocks arrived by prefetch and which by demand. Every completed window of issued prefetches compares the useful-to-issued ratio against an upper and a lower threshold. The degree then moves one step up or down, within fixed limits.

Top module: `tagged_seq_prefetch`

## Requirements
- R1: A trigger on block b while the degree is K > 0 makes `pf_valid` high for exactly the next K cycles, with `pf_blk` equal to b+1, b+2, ... b+K in that order, the first one in the cycle after the access is sampled.
- R2: With `mode_tagged` = 0, only an access with `acc_hit` = 0 triggers; a hit never triggers, marked or not.
- R3: With `mode_tagged` = 1, an access triggers when it misses, or when it hits a block whose mark is set and whose stored upper bits match; that hit clears the mark, so a second hit on the same block does not trigger.
- R4: A fill with `fill_pf` = 1 sets the mark of `fill_blk` and a fill with `fill_pf` = 0 clears it; the entry is selected by the low IDX_W bits (6 by default) and stores the remaining upper bits; a block that shares the entry but differs in the upper bits sees no mark; when a fill and a mark-clearing hit touch the same entry in one cycle, the fill's value is kept.
- R5: A hit that clears a mark counts as one useful prefetch in either mode, even when it causes no trigger.
- R6: A trigger that arrives while a burst is running abandons the rest of that burst; the address on `pf_blk` in that cycle is still issued, and the new burst starts in the next cycle.
- R7: After every WIN (256) issued prefetches the degree rises by one if useful*100 > 75*WIN, falls by one if useful*100 < 40*WIN, and stays otherwise; the useful count saturates at WIN, both counters restart at zero, and the new degree is visible on `degree` in the following cycle.
- R8: The degree stays within 0 to 8; at 8 it does not rise, at 0 it does not fall, and a trigger at degree 0 issues nothing.
- R9: After reset, `pf_valid` is 0, `degree` is 1 and every mark is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tagged | input | 1 | 0: trigger on miss only; 1: also trigger on the first use of a prefetched block |
| acc_valid | input | 1 | A demand access is present this cycle |
| acc_blk | input | BLK_W | Block address of the demand access |
| acc_hit | input | 1 | The demand access hit in the cache |
| fill_valid | input | 1 | A block was written into the cache this cycle |
| fill_blk | input | BLK_W | Block address of the fill |
| fill_pf | input | 1 | 1: the fill came from a prefetch; 0: it came from a demand miss |
| pf_valid | output | 1 | A prefetch address is issued this cycle |
| pf_blk | output | BLK_W | Block address to prefetch |
| degree | output | DW | Current prefetch degree K |

## Verification
The assertions assume that every input is a known value in each cycle outside reset. They also assume that `acc_hit` is only meaningful while `acc_valid` is high. The stimulus holds to this by driving every input from defined values at the falling edge and by zeroing the access and fill fields whenever their valid bit is low. The properties make no assumption about whether a hit was truly cached, so the random phase mixes hits and misses on a small address range freely. That phase also lets fills and accesses collide on the same entry, which exercises the priority rule.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic {
        MODE_ON_MISS = 1'b0,
        MODE_TAGGED  = 1'b1
    } pf_mode_e;

    // True when num/den exceeds pct percent, kept in integers.
    function automatic logic ratio_above(input int num, input int den, input int pct);
        return (num * 100) > (pct * den);
    endfunction

    // True when num/den falls short of pct percent.
    function automatic logic ratio_below(input int num, input int den, input int pct);
        return (num * 100) < (pct * den);
    endfunction

endpackage

// File: rtl/pfx_tag_store.sv
module pfx_tag_store
    import pfx_pkg::*;
#(
    parameter int BLK_W = 26,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pf_mode_e         mode,
    input  logic             acc_valid,
    input  logic [BLK_W-1:0] acc_blk,
    input  logic             acc_hit,
    input  logic             fill_valid,
    input  logic [BLK_W-1:0] fill_blk,
    input  logic             fill_pf,
    output logic             trig,
    output logic             useful
);
    localparam int HI_W  = BLK_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0]           mark;
        logic [DEPTH-1:0][HI_W-1:0] upper;
    } tag_st_t;

    tag_st_t st_d, st_q;

    logic [IDX_W-1:0] a_idx, f_idx;
    logic [HI_W-1:0]  a_hi, f_hi;
    logic             mark_hit;

    assign a_idx = acc_blk[IDX_W-1:0];
    assign a_hi  = acc_blk[BLK_W-1:IDX_W];
    assign f_idx = fill_blk[IDX_W-1:0];
    assign f_hi  = fill_blk[BLK_W-1:IDX_W];

    always_comb begin
        st_d     = st_q;
        mark_hit = acc_valid && acc_hit && st_q.mark[a_idx] && (st_q.upper[a_idx] == a_hi);
        useful   = mark_hit;
        trig     = acc_valid && (!acc_hit || ((mode == MODE_TAGGED) && mark_hit));
        if (mark_hit) begin
            st_d.mark[a_idx] = 1'b0;
        end
        // A fill is written last, so it wins over a same-entry clear.
        if (fill_valid) begin
            st_d.mark[f_idx]  = fill_pf;
            st_d.upper[f_idx] = f_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pfx_burst_issuer.sv
module pfx_burst_issuer #(
    parameter int BLK_W = 26,
    parameter int DW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [BLK_W-1:0] base_blk,
    input  logic [DW-1:0]    degree,
    output logic             pf_valid,
    output logic [BLK_W-1:0] pf_blk
);
    typedef struct packed {
        logic [BLK_W-1:0] nxt;
        logic [DW-1:0]    left;
    } burst_st_t;

    burst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.nxt  = base_blk + BLK_W'(1);
            st_d.left = degree;
        end else if (st_q.left != '0) begin
            st_d.nxt  = st_q.nxt + BLK_W'(1);
            st_d.left = st_q.left - DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pf_valid = (st_q.left != '0);
    assign pf_blk   = st_q.nxt;

endmodule

// File: rtl/pfx_degree_ctrl.sv
module pfx_degree_ctrl
    import pfx_pkg::*;
#(
    parameter int WIN    = 256,
    parameter int K_MAX  = 8,
    parameter int K_INIT = 1,
    parameter int HI_PCT = 75,
    parameter int LO_PCT = 40,
    parameter int DW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issued,
    input  logic          useful,
    output logic [DW-1:0] degree
);
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] used;
        logic [DW-1:0] k;
    } deg_st_t;

    deg_st_t st_d, st_q;
    int      used_sum;

    always_comb begin
        st_d     = st_q;
        used_sum = int'(st_q.used) + int'(useful);
        if (used_sum > WIN) begin
            used_sum = WIN;
        end
        st_d.used = CW'(used_sum);
        if (issued) begin
            if (st_q.cnt == CW'(WIN - 1)) begin
                st_d.cnt  = '0;
                st_d.used = '0;
                if (ratio_above(used_sum, WIN, HI_PCT) && (int'(st_q.k) < K_MAX)) begin
                    st_d.k = st_q.k + DW'(1);
                end else if (ratio_below(used_sum, WIN, LO_PCT) && (st_q.k != '0)) begin
                    st_d.k = st_q.k - DW'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.k   <= DW'(K_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign degree = st_q.k;

endmodule

// File: rtl/tagged_seq_prefetch.sv
module tagged_seq_prefetch
    import pfx_pkg::*;
#(
    parameter int BLK_W  = 26,
    parameter int IDX_W  = 6,
    parameter int K_MAX  = 8,
    parameter int K_INIT = 1,
    parameter int WIN    = 256,
    parameter int HI_PCT = 75,
    parameter int LO_PCT = 40,
    localparam int DW    = $clog2(K_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_tagged,
    input  logic             acc_valid,
    input  logic [BLK_W-1:0] acc_blk,
    input  logic             acc_hit,
    input  logic             fill_valid,
    input  logic [BLK_W-1:0] fill_blk,
    input  logic             fill_pf,
    output logic             pf_valid,
    output logic [BLK_W-1:0] pf_blk,
    output logic [DW-1:0]    degree
);
    pf_mode_e mode;
    logic     trig;
    logic     useful;

    assign mode = pf_mode_e'(mode_tagged);

    pfx_tag_store #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .acc_valid (acc_valid),
        .acc_blk   (acc_blk),
        .acc_hit   (acc_hit),
        .fill_valid(fill_valid),
        .fill_blk  (fill_blk),
        .fill_pf   (fill_pf),
        .trig      (trig),
        .useful    (useful)
    );

    pfx_burst_issuer #(.BLK_W(BLK_W), .DW(DW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .base_blk(acc_blk),
        .degree  (degree),
        .pf_valid(pf_valid),
        .pf_blk  (pf_blk)
    );

    pfx_degree_ctrl #(
        .WIN(WIN), .K_MAX(K_MAX), .K_INIT(K_INIT),
        .HI_PCT(HI_PCT), .LO_PCT(LO_PCT), .DW(DW)
    ) u_deg (
        .clk   (clk),
        .rst_n (rst_n),
        .issued(pf_valid),
        .useful(useful),
        .degree(degree)
    );

endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
    parameter int BLK_W = 26,
    parameter int K_MAX = 8,
    parameter int DW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_tagged,
    input logic             acc_valid,
    input logic [BLK_W-1:0] acc_blk,
    input logic             acc_hit,
    input logic             trig,
    input logic             pf_valid,
    input logic [BLK_W-1:0] pf_blk,
    input logic [DW-1:0]    degree
);
    assert_degree_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(degree) <= K_MAX);

    assert_degree_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int'(degree) - int'($past(degree))) <= 1 &&
                  (int'($past(degree)) - int'(degree)) <= 1));

    assert_onmiss_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode_tagged && acc_hit) |-> !trig);

    // R2 and R3: a miss triggers in both modes
    assert_miss_triggers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |-> trig);

    assert_burst_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && degree != '0) |=> (pf_valid && pf_blk == $past(acc_blk) + BLK_W'(1)));

    assert_burst_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !trig) |=> (!pf_valid || pf_blk == $past(pf_blk) + BLK_W'(1)));

    assert_zero_degree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && degree == '0) |=> !pf_valid);

endmodule

bind tagged_seq_prefetch pfx_checker #(.BLK_W(BLK_W), .K_MAX(K_MAX), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_tagged(mode_tagged),
    .acc_valid  (acc_valid),
    .acc_blk    (acc_blk),
    .acc_hit    (acc_hit),
    .trig       (trig),
    .pf_valid   (pf_valid),
    .pf_blk     (pf_blk),
    .degree     (degree)
);

// File: tb/sim_tagged_seq_prefetch.sv
`timescale 1ns/1ps
module sim_tagged_seq_prefetch;
    localparam int BW   = 26;
    localparam int NIDX = 64;
    localparam int WINL = 256;
    localparam int KTOP = 8;
    localparam int MASK = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_tagged = 1'b0;
    logic          acc_valid = 1'b0;
    logic [BW-1:0] acc_blk = '0;
    logic          acc_hit = 1'b0;
    logic          fill_valid = 1'b0;
    logic [BW-1:0] fill_blk = '0;
    logic          fill_pf = 1'b0;
    logic          pf_valid;
    logic [BW-1:0] pf_blk;
    logic [3:0]    degree;

    always #4 clk = ~clk;

    tagged_seq_prefetch u0 (.*);

    int total = 0;
    int bad = 0;

    // expected-state of the block, built from the requirements
    int m_mark[NIDX];
    int m_up[NIDX];
    int m_nxt, m_left, m_k, m_cnt, m_used;
    bit pend_v = 0;
    int pend_b = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NIDX; i++) begin
            m_mark[i] = 0;
            m_up[i] = 0;
        end
        m_nxt = 0; m_left = 0; m_k = 1; m_cnt = 0; m_used = 0;
        pend_v = 0;
    endtask

    task automatic model_step(input bit md, input bit av, input int blk, input bit hit,
                              input bit fv, input int fblk, input bit fpf);
        int  idx, up, us, k_old;
        bit  mh, tr, iss;
        idx   = blk % NIDX;
        up    = blk / NIDX;
        mh    = av && hit && (m_mark[idx] != 0) && (m_up[idx] == up);
        tr    = av && (!hit || (md && mh));
        iss   = (m_left != 0);
        k_old = m_k;
        us = m_used + (mh ? 1 : 0);
        if (us > WINL) us = WINL;
        m_used = us;
        if (iss) begin
            if (m_cnt == WINL - 1) begin
                m_cnt = 0; m_used = 0;
                if (us * 100 > 75 * WINL && m_k < KTOP) m_k++;
                else if (us * 100 < 40 * WINL && m_k > 0) m_k--;
            end else begin
                m_cnt++;
            end
        end
        if (tr) begin
            m_nxt = (blk + 1) & MASK; m_left = k_old;
        end else if (m_left != 0) begin
            m_nxt = (m_nxt + 1) & MASK; m_left--;
        end
        if (mh) m_mark[idx] = 0;
        if (fv) begin
            m_mark[fblk % NIDX] = fpf;
            m_up[fblk % NIDX] = fblk / NIDX;
        end
    endtask

    task automatic cyc(input bit md, input bit av, input int blk, input bit hit,
                       input bit fv, input int fblk, input bit fpf);
        mode_tagged = md;
        acc_valid   = av;
        acc_blk     = av ? BW'(blk) : '0;
        acc_hit     = av ? hit : 1'b0;
        fill_valid  = fv;
        fill_blk    = fv ? BW'(fblk) : '0;
        fill_pf     = fv ? fpf : 1'b0;
        model_step(md, av, av ? blk : 0, av ? hit : 1'b0, fv, fv ? fblk : 0, fv ? fpf : 1'b0);
        @(posedge clk);
        #1;
        chk(pf_valid === (m_left != 0), "R1 pf_valid vs expected", int'(pf_valid), int'(m_left != 0));
        if (m_left != 0)
            chk(int'(pf_blk) == m_nxt, "R1 pf_blk vs expected", int'(pf_blk), m_nxt);
        chk(int'(degree) == m_k, "R7 degree vs expected", int'(degree), m_k);
        pend_v = pf_valid;
        pend_b = int'(pf_blk);
        @(negedge clk);
    endtask

    // access with the previous cycle's prefetch written back as a fill when af is set
    task automatic step(input bit md, input bit av, input int blk, input bit hit, input bit af);
        cyc(md, av, blk, hit, af && pend_v, pend_b, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        acc_valid = 1'b0; fill_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b, kk, guard;
        void'($urandom(32'd20240611));
        do_reset();
        @(posedge clk); #1;
        chk(pf_valid == 1'b0, "R9 pf_valid after reset", int'(pf_valid), 0);
        chk(degree == 4'd1, "R9 degree after reset", int'(degree), 1);
        @(negedge clk);

        // R9: marks clear after reset, tagged hit does not trigger
        step(1, 1, 7, 1, 0);
        chk(pf_valid == 1'b0, "R9 no mark after reset", int'(pf_valid), 0);

        // R2: miss triggers in on-miss mode, hit does not
        cyc(0, 1, 100, 0, 0, 0, 0);
        chk(pf_valid && pf_blk == 26'd101, "R2 miss starts prefetch of b+1", int'(pf_blk), 101);
        step(0, 0, 0, 0, 1);
        chk(pf_valid == 1'b0, "R1 burst of one ends", int'(pf_valid), 0);
        step(0, 1, 101, 1, 0);
        chk(pf_valid == 1'b0, "R2 hit on marked block quiet in on-miss mode", int'(pf_valid), 0);

        // R3: tagged mode first use triggers, second does not
        cyc(1, 1, 200, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);
        step(1, 1, 201, 1, 0);
        chk(pf_valid && pf_blk == 26'd202, "R3 first use of prefetched block", int'(pf_blk), 202);
        step(1, 1, 201, 1, 0);
        chk(pf_valid == 1'b0, "R3 second use no trigger", int'(pf_valid), 0);
        step(1, 1, 300, 1, 0);
        chk(pf_valid == 1'b0, "R3 unmarked hit no trigger", int'(pf_valid), 0);

        // R4: aliasing entry, demand fill clear, fill priority
        cyc(1, 0, 0, 0, 1, 69, 1);
        step(1, 1, 5, 1, 0);
        chk(pf_valid == 1'b0, "R4 alias with other upper bits", int'(pf_valid), 0);
        step(1, 1, 69, 1, 0);
        chk(pf_valid && pf_blk == 26'd70, "R4 matching upper bits", int'(pf_blk), 70);
        cyc(1, 0, 0, 0, 1, 400, 1);
        cyc(1, 0, 0, 0, 1, 400, 0);
        step(1, 1, 400, 1, 0);
        chk(pf_valid == 1'b0, "R4 demand fill clears mark", int'(pf_valid), 0);
        cyc(1, 0, 0, 0, 1, 500, 1);
        cyc(1, 1, 500, 1, 1, 500, 1);
        chk(pf_valid && pf_blk == 26'd501, "R4 hit with same-entry fill", int'(pf_blk), 501);
        step(1, 1, 500, 1, 0);
        chk(pf_valid && pf_blk == 26'd501, "R4 fill wins over clear", int'(pf_blk), 501);
        step(1, 0, 0, 0, 0);

        // R5/R7/R8: fully used on-miss stream drives the degree to the top
        b = 4096; guard = 0;
        while (guard < 4000 && !(degree == 4'd8 && guard > 600)) begin
            kk = int'(degree);
            step(0, 1, b, 0, 1);
            while (pend_v) step(0, 0, 0, 0, 1);
            step(0, 0, 0, 0, 1);
            for (int j = 1; j <= kk; j++) step(0, 1, b + j, 1, 1);
            b = b + kk + 1;
            if (b > 60000) b = 4096;
            guard++;
            if (guard == 300)
                chk(degree >= 4'd2, "R5 useful hits raise degree", int'(degree), 2);
        end
        chk(degree == 4'd8, "R8 degree held at upper limit", int'(degree), 8);

        // R6: restart of a running burst
        cyc(0, 1, 10000, 0, 0, 0, 0);
        chk(pf_blk == 26'd10001, "R6 first of burst", int'(pf_blk), 10001);
        step(0, 0, 0, 0, 0);
        chk(pf_blk == 26'd10002, "R6 second of burst", int'(pf_blk), 10002);
        cyc(0, 1, 20000, 0, 0, 0, 0);
        chk(pf_valid && pf_blk == 26'd20001, "R6 new burst replaces old", int'(pf_blk), 20001);
        step(0, 0, 0, 0, 0);
        chk(pf_blk == 26'd20002, "R6 new burst continues", int'(pf_blk), 20002);

        // R7/R8: useless prefetches drive the degree to zero
        guard = 0;
        while (degree != 4'd0 && guard < 5000) begin
            step(1, 1, 30000 + guard * 97, 0, 0);
            guard++;
        end
        chk(degree == 4'd0, "R7 unused prefetches lower degree", int'(degree), 0);
        repeat (3) step(1, 0, 0, 0, 0);
        step(1, 1, 777, 0, 0);
        chk(pf_valid == 1'b0, "R8 degree zero issues nothing", int'(pf_valid), 0);
        chk(degree == 4'd0, "R8 degree held at lower limit", int'(degree), 0);

        // random phase, checked cycle by cycle against the expected state
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            bit md, av, hit, fv, fpf;
            int blk, fblk;
            md  = ((n / 500) % 2) == 1;
            av  = ($urandom % 10) < 7;
            blk = $urandom % 128;
            hit = $urandom % 2;
            if (pend_v) begin
                fv = 1; fblk = pend_b; fpf = 1;
            end else begin
                fv = ($urandom % 5) == 0;
                fblk = $urandom % 128;
                fpf = $urandom % 2;
            end
            cyc(md, av, blk, hit, fv, fblk, fpf);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule